// File: doc/BRIEF.md
# Line Alarm Status Indicator Monitor

This block watches the alarm status of a high-rate framed serial line and turns it into indicator outputs. Each time the status source presents a fresh set of framer status words, qualified by `stat_valid_i`, the block works out three alarm conditions and latches them. The conditions are local red (the receiver has lost signal or lost frame), far-end (the far end is signalling alarm, or an X-bit error is flagged), and blue (the receiver sees an all-ones signal). A ready indicator is held on.

For each alarm the block keeps the latched state and emits a one-cycle pulse when the alarm first appears and another when it goes away. Repeated samples that report the same condition produce no further pulses. When the local red alarm is entered or left, the block asks the transmit side to set or clear its far-end error flag. It does this with a single-cycle request that carries a set/clear qualifier and is meant to drive a read-modify-write of the transmit control register. Reading the framer is done elsewhere; this block sees only the status words.

Top module: `line_alarm_monitor`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, all three alarm indicators are 0, the ready indicator is 1, and every event pulse and the transmit request are 0.
- R2: The red indicator equals LOS OR OOF from the last accepted sample, where LOS is `stat0_i` bit 0 and OOF is `stat0_i` bit 1.
- R3: The far-end indicator equals AIS OR XERR from the last accepted sample, where AIS is `stat0_i` bit 2 and XERR is `stat10_i` bit 4.
- R4: The blue indicator equals `stat9_i` bit 3 from the last accepted sample.
- R5: A sample is accepted only at a rising clock edge with `stat_valid_i` high, and indicators change in the cycle after that edge. With `stat_valid_i` low, the indicators hold and no pulse or request is produced.
- R6: `raise_o` bit k pulses for exactly one cycle when an accepted sample sets alarm k while it was clear, with bit 0 far-end, bit 1 blue and bit 2 red. It does not pulse on repeated samples of an alarm that is already set.
- R7: `clear_o` bit k, using the same bit order as R6, pulses for exactly one cycle when an accepted sample clears alarm k while it was set.
- R8: `xerr_req_o` pulses in the same cycle as a red raise or red clear pulse and at no other time. `xerr_set_o` is 1 with a request on red entry and 0 with a request on red exit.
- R9: Status bits other than those named in R2 to R4 have no effect on any output.
- R10: The ready indicator is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_valid_i | input | 1 | Status words are valid this cycle |
| stat0_i | input | 16 | Primary receive status word (LOS, OOF, AIS) |
| stat9_i | input | 16 | Receive pattern status word (all-ones) |
| stat10_i | input | 16 | Receive overhead status word (X-bit error) |
| led_ready_o | output | 1 | Ready indicator |
| led_far_o | output | 1 | Far-end alarm indicator |
| led_blue_o | output | 1 | Blue alarm indicator |
| led_red_o | output | 1 | Local red alarm indicator |
| raise_o | output | 3 | Alarm-entry pulses {red, blue, far} |
| clear_o | output | 3 | Alarm-exit pulses {red, blue, far} |
| xerr_req_o | output | 1 | Transmit far-end error update request |
| xerr_set_o | output | 1 | Qualifier: 1 set, 0 clear |

## Verification
Two things can land in one cycle: a red-alarm edge with its transmit request, and the entry or exit of the far-end or blue alarm in the same sample. There can also be a raise on one alarm and a clear on another. Every ordered pair of the 32 combinations of the five relevant bits is applied back to back, so each pairing of edges across the three alarms occurs in a single accepted sample. Every pulse vector and the request qualifier are compared against a model in the bench for that cycle. Unrelated status bits carry a changing pattern throughout, and invalid cycles carrying a different word are interleaved.

// File: rtl/lam_pkg.sv
package lam_pkg;
  localparam int unsigned N_IND   = 3;
  localparam int unsigned IND_FAR  = 0;
  localparam int unsigned IND_BLUE = 1;
  localparam int unsigned IND_RED  = 2;
  typedef logic [N_IND-1:0] ind_vec_t;
endpackage

// File: rtl/lam_decode.sv
module lam_decode
  import lam_pkg::*;
#(
  parameter int unsigned STAT_W   = 16,
  parameter int unsigned LOS_BIT  = 0,
  parameter int unsigned OOF_BIT  = 1,
  parameter int unsigned AIS_BIT  = 2,
  parameter int unsigned BLUE_BIT = 3,
  parameter int unsigned XERR_BIT = 4
) (
  input  logic [STAT_W-1:0] stat0_i,
  input  logic [STAT_W-1:0] stat9_i,
  input  logic [STAT_W-1:0] stat10_i,
  output ind_vec_t          raw_o
);
  localparam logic [STAT_W-1:0] RED_MASK  = (STAT_W'(1) << LOS_BIT) | (STAT_W'(1) << OOF_BIT);
  localparam logic [STAT_W-1:0] AIS_MASK  = STAT_W'(1) << AIS_BIT;
  localparam logic [STAT_W-1:0] BLUE_MASK = STAT_W'(1) << BLUE_BIT;
  localparam logic [STAT_W-1:0] XERR_MASK = STAT_W'(1) << XERR_BIT;

  always_comb begin
    raw_o           = '0;
    raw_o[IND_RED]  = |(stat0_i & RED_MASK);
    raw_o[IND_FAR]  = |(stat0_i & AIS_MASK) | |(stat10_i & XERR_MASK);
    raw_o[IND_BLUE] = |(stat9_i & BLUE_MASK);
  end
endmodule

// File: rtl/lam_tracker.sv
module lam_tracker
  import lam_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     valid_i,
  input  ind_vec_t raw_i,
  output ind_vec_t state_o,
  output ind_vec_t rise_nxt_o,
  output ind_vec_t fall_nxt_o,
  output ind_vec_t rise_o,
  output ind_vec_t fall_o
);
  ind_vec_t state_q, rise_q, fall_q;

  for (genvar g = 0; g < N_IND; g++) begin : g_ind
    assign rise_nxt_o[g] = valid_i &  raw_i[g] & ~state_q[g];
    assign fall_nxt_o[g] = valid_i & ~raw_i[g] &  state_q[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        state_q[g] <= 1'b0;
        rise_q[g]  <= 1'b0;
        fall_q[g]  <= 1'b0;
      end else begin
        if (valid_i) state_q[g] <= raw_i[g];
        rise_q[g] <= rise_nxt_o[g];
        fall_q[g] <= fall_nxt_o[g];
      end
    end
  end

  assign state_o = state_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
endmodule

// File: rtl/lam_xerr_req.sv
module lam_xerr_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic leave_i,
  output logic req_o,
  output logic set_o
);
  logic req_q, set_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      set_q <= 1'b0;
    end else begin
      req_q <= enter_i | leave_i;
      // qualifier holds its last value between requests
      if (enter_i | leave_i) set_q <= enter_i;
    end
  end

  assign req_o = req_q;
  assign set_o = set_q;
endmodule

// File: rtl/line_alarm_monitor.sv
module line_alarm_monitor
  import lam_pkg::*;
#(
  parameter int unsigned STAT_W   = 16,
  parameter int unsigned LOS_BIT  = 0,
  parameter int unsigned OOF_BIT  = 1,
  parameter int unsigned AIS_BIT  = 2,
  parameter int unsigned BLUE_BIT = 3,
  parameter int unsigned XERR_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stat_valid_i,
  input  logic [STAT_W-1:0] stat0_i,
  input  logic [STAT_W-1:0] stat9_i,
  input  logic [STAT_W-1:0] stat10_i,
  output logic              led_ready_o,
  output logic              led_far_o,
  output logic              led_blue_o,
  output logic              led_red_o,
  output logic [2:0]        raise_o,
  output logic [2:0]        clear_o,
  output logic              xerr_req_o,
  output logic              xerr_set_o
);
  ind_vec_t raw, state, rise_nxt, fall_nxt, rise, fall;
  logic     ready_q;

  lam_decode #(
    .STAT_W(STAT_W), .LOS_BIT(LOS_BIT), .OOF_BIT(OOF_BIT),
    .AIS_BIT(AIS_BIT), .BLUE_BIT(BLUE_BIT), .XERR_BIT(XERR_BIT)
  ) u_decode (
    .stat0_i (stat0_i),
    .stat9_i (stat9_i),
    .stat10_i(stat10_i),
    .raw_o   (raw)
  );

  lam_tracker u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (stat_valid_i),
    .raw_i     (raw),
    .state_o   (state),
    .rise_nxt_o(rise_nxt),
    .fall_nxt_o(fall_nxt),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  lam_xerr_req u_xerr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .enter_i(rise_nxt[IND_RED]),
    .leave_i(fall_nxt[IND_RED]),
    .req_o  (xerr_req_o),
    .set_o  (xerr_set_o)
  );

  // ready is re-asserted on every evaluation and survives reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ready_q <= 1'b1;
    else if (stat_valid_i) ready_q <= 1'b1;
  end

  assign led_ready_o = ready_q;
  assign led_far_o   = state[IND_FAR];
  assign led_blue_o  = state[IND_BLUE];
  assign led_red_o   = state[IND_RED];
  assign raise_o     = rise;
  assign clear_o     = fall;
endmodule

// File: rtl/lam_checker.sv
module lam_checker #(
  parameter int unsigned STAT_W   = 16,
  parameter int unsigned LOS_BIT  = 0,
  parameter int unsigned OOF_BIT  = 1,
  parameter int unsigned AIS_BIT  = 2,
  parameter int unsigned BLUE_BIT = 3,
  parameter int unsigned XERR_BIT = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stat_valid_i,
  input logic [STAT_W-1:0] stat0_i,
  input logic [STAT_W-1:0] stat9_i,
  input logic [STAT_W-1:0] stat10_i,
  input logic              led_ready_o,
  input logic              led_far_o,
  input logic              led_blue_o,
  input logic              led_red_o,
  input logic [2:0]        raise_o,
  input logic [2:0]        clear_o,
  input logic              xerr_req_o,
  input logic              xerr_set_o
);
  logic red_in, far_in, blue_in;
  assign red_in  = stat0_i[LOS_BIT] | stat0_i[OOF_BIT];
  assign far_in  = stat0_i[AIS_BIT] | stat10_i[XERR_BIT];
  assign blue_in = stat9_i[BLUE_BIT];

  AST_RED_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_i |=> led_red_o == $past(red_in)); // R2
  AST_FAR_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_i |=> led_far_o == $past(far_in)); // R3
  AST_BLUE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_i |=> led_blue_o == $past(blue_in)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_valid_i |=> $stable({led_far_o, led_blue_o, led_red_o})
                      && raise_o == 3'b0 && clear_o == 3'b0 && !xerr_req_o); // R5
  AST_RAISE_LIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raise_o & ~{led_red_o, led_blue_o, led_far_o}) == 3'b0); // R6
  AST_CLEAR_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_o & {led_red_o, led_blue_o, led_far_o}) == 3'b0); // R7
  AST_REQ_ON_RED_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xerr_req_o == (raise_o[2] | clear_o[2])); // R8
  AST_REQ_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xerr_req_o |-> xerr_set_o == led_red_o); // R8
  AST_READY_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_ready_o); // R10
endmodule

bind line_alarm_monitor lam_checker #(
  .STAT_W(STAT_W), .LOS_BIT(LOS_BIT), .OOF_BIT(OOF_BIT),
  .AIS_BIT(AIS_BIT), .BLUE_BIT(BLUE_BIT), .XERR_BIT(XERR_BIT)
) u_lam_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .stat_valid_i(stat_valid_i),
  .stat0_i(stat0_i), .stat9_i(stat9_i), .stat10_i(stat10_i),
  .led_ready_o(led_ready_o), .led_far_o(led_far_o), .led_blue_o(led_blue_o),
  .led_red_o(led_red_o), .raise_o(raise_o), .clear_o(clear_o),
  .xerr_req_o(xerr_req_o), .xerr_set_o(xerr_set_o)
);

// File: tb/tb_line_alarm_monitor.sv
module tb_line_alarm_monitor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        stat_valid_i = 1'b0;
  logic [15:0] stat0_i = '0, stat9_i = '0, stat10_i = '0;
  logic        led_ready_o, led_far_o, led_blue_o, led_red_o;
  logic [2:0]  raise_o, clear_o;
  logic        xerr_req_o, xerr_set_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [2:0] st = '0;

  always #10 clk_i = ~clk_i;

  line_alarm_monitor dut (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bits of w: 0 LOS, 1 OOF, 2 AIS, 3 blue, 4 X-bit error
  task automatic apply(logic [4:0] w, bit vld, logic [15:0] noise);
    logic [2:0] nw, rs, fl;
    logic req, setq;
    @(negedge clk_i);
    stat_valid_i = vld;
    stat0_i  = (noise & ~16'h0007) | {13'b0, w[2:0]};
    stat9_i  = (~noise & ~16'h0008) | {12'b0, w[3], 3'b0};
    stat10_i = ({noise[7:0], noise[15:8]} & ~16'h0010) | {11'b0, w[4], 4'b0};
    nw = {w[0] | w[1], w[3], w[2] | w[4]};
    if (vld) begin
      rs = nw & ~st; fl = ~nw & st; st = nw;
    end else begin
      rs = '0; fl = '0;
    end
    req = rs[2] | fl[2];
    setq = rs[2];
    @(negedge clk_i);
    chk("R2 red",   {7'b0, led_red_o},  {7'b0, st[2]});
    chk("R3 far",   {7'b0, led_far_o},  {7'b0, st[0]});
    chk("R4 blue",  {7'b0, led_blue_o}, {7'b0, st[1]});
    chk("R6 raise", {5'b0, raise_o}, {5'b0, rs});
    chk("R7 clear", {5'b0, clear_o}, {5'b0, fl});
    chk("R8 req",   {6'b0, xerr_req_o, xerr_req_o & xerr_set_o}, {6'b0, req, setq});
    chk("R10 ready", {7'b0, led_ready_o}, 8'd1);
    if (!vld) chk("R5 hold no pulse", {raise_o, clear_o, xerr_req_o}, 8'd0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset", {led_ready_o, led_far_o, led_blue_o, led_red_o, xerr_req_o, 3'b0}, 8'h80);
    chk("R1 reset pulses", {2'b0, raise_o, clear_o}, 8'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", {led_ready_o, led_far_o, led_blue_o, led_red_o, xerr_req_o, 3'b0}, 8'h80);
    // repeated identical sample: no second pulse (R6)
    apply(5'b00001, 1, 16'h1234);
    apply(5'b00001, 1, 16'hBEEF);
    apply(5'b00010, 1, 16'h0F0F);
    // every ordered pair, with invalid samples interleaved (R5, R9)
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        apply(5'(a), 1, 16'((a * 40503 + b * 2654) ^ 16'h5A5A));
        apply(5'(b), 1, 16'((b * 977 + a * 31) ^ 16'hC3C3));
        if (((a + b) % 7) == 0)
          apply(5'(~b), 0, 16'(a * 13 + b));
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule